// File: doc/BRIEF.md
# Address Quadrant Qualifier and Fault Reporter

This block sits in front of a radix-tree address translator. For each access it looks at the two top bits of the 64-bit effective address (the quadrant) and at the hypervisor-mode flag. From these it decides which partition ID and which process ID the translation should use. If the address cannot be translated, it raises a segment fault instead. This side of the block is purely combinational, so the translator can start its walk in the same cycle.

The second side is a registered fault port. When a translation step fails, the translator presents a fault class (segment, guest storage or host storage), a cause word and the guest real address, and pulses a strobe. On that clock edge the block updates all of the fault-state registers at once. The registers are the exception index, the data address, the data status, the host status, the host data address, the secondary address and the error code. One cycle later the block raises a fault-valid pulse. For stores, the store flag is merged into any status word before it is recorded.

Top module: `addr_qual_fault`

## Requirements
- R1: An effective address with any bit set in the reserved range (bits 61 down to 62-RSVD_HI, default 61:52) gives seg_fault=1, whatever the mode. Whenever seg_fault is 1, sel_lpid and sel_pid are 0.
- R2: With hv_mode=1, the quadrant ea[63:62] selects the IDs as follows: 0 gives LPID 0 with the current PID; 1 gives the current LPID with the current PID; 2 gives the current LPID with PID 0; 3 gives LPID 0 with PID 0. No segment fault is raised.
- R3: With hv_mode=0, quadrant 0 gives the current LPID and the current PID, and quadrant 3 gives the current LPID with PID 0. Quadrants 1 and 2 give seg_fault=1.
- R4: A segment-class fault (flt_class=0) sets the error code to 0. Access codes are 0 fetch, 1 load, 2 store. On a fetch it writes exception index 1 and leaves the data address unchanged. On a load or store it writes exception index 2 and records ea in the data address.
- R5: A guest-storage fault (flt_class=1) on a fetch writes exception index 3 and copies the raw cause into the error code. On a load or store it writes exception index 4, writes the cause into the data status, writes ea into the data address and clears the error code.
- R6: On a store, bit STORE_BIT (default 25) of the cause is forced to 1 before it is written to the data status or the host status.
- R7: A host-storage fault (flt_class=2) always writes the guest real address into the secondary address. On a fetch it writes exception index 5 and copies the raw cause into the error code. On a load or store it writes exception index 6, the cause into the host status and ea into the host data address, and clears the error code.
- R8: Fault registers change only on a clock edge where flt_strobe=1 with flt_class 0 to 2. flt_class=3 changes nothing. flt_valid is high for exactly the cycle after each accepted strobe.
- R9: Reset clears every fault register and flt_valid to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ea | input | 64 | Effective address of the access |
| hv_mode | input | 1 | Hypervisor privilege mode |
| acc_type | input | 2 | 0 fetch, 1 load, 2 store |
| cur_lpid | input | 32 | Current partition ID |
| cur_pid | input | 32 | Current process ID |
| sel_lpid | output | 32 | Selected partition ID |
| sel_pid | output | 32 | Selected process ID |
| seg_fault | output | 1 | Address cannot be qualified |
| flt_strobe | input | 1 | Record a fault this cycle |
| flt_class | input | 2 | 0 segment, 1 guest storage, 2 host storage, 3 none |
| flt_cause | input | 32 | Fault cause word |
| flt_graddr | input | 64 | Guest real address of a host fault |
| flt_valid | output | 1 | One-cycle pulse after a recorded fault |
| exc_idx | output | 3 | Exception index |
| err_code | output | 32 | Error code |
| data_addr | output | 64 | Data address register |
| data_stat | output | 32 | Data status register |
| host_stat | output | 32 | Host status register |
| host_addr | output | 64 | Host data address register |
| sec_addr | output | 64 | Secondary address register |

## Verification
Directed cases visit all four quadrants in both modes. Because each quadrant is given a distinct current LPID and PID, any swap between the two IDs or with zero is visible. An address with one reserved bit set, in an otherwise legal quadrant, separates the mask check from the quadrant check. The fault port is driven with every class crossed with every access type. A data fault issued before a segment fetch fault shows whether the data address truly holds. Class 3 and idle cycles show whether state leaks through. Random stimulus then mixes cause words, addresses and IDs, so wrong bit placement of the store flag or of a routed field is caught.

// File: rtl/aq_pkg.sv
package aq_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    FC_SEG   = 2'd0,
    FC_GUEST = 2'd1,
    FC_HOST  = 2'd2,
    FC_NONE  = 2'd3
  } fclass_e;

  typedef enum logic [2:0] {
    EX_NONE   = 3'd0,
    EX_ISEG   = 3'd1,
    EX_DSEG   = 3'd2,
    EX_ISTOR  = 3'd3,
    EX_DSTOR  = 3'd4,
    EX_HISTOR = 3'd5,
    EX_HDSTOR = 3'd6
  } exc_e;
endpackage

// File: rtl/aq_quadrant_sel.sv
module aq_quadrant_sel #(
  parameter int EA_W    = 64,
  parameter int RSVD_HI = 10,
  parameter int LPID_W  = 32,
  parameter int PID_W   = 32
) (
  input  logic [EA_W-1:0]   ea,
  input  logic              hv_mode,
  input  logic [LPID_W-1:0] cur_lpid,
  input  logic [PID_W-1:0]  cur_pid,
  output logic [LPID_W-1:0] sel_lpid,
  output logic [PID_W-1:0]  sel_pid,
  output logic              seg_fault
);
  localparam int QUAD_LO  = EA_W - 2;
  localparam int RSVD_TOP = EA_W - 3;
  localparam int RSVD_BOT = EA_W - 2 - RSVD_HI;

  logic [1:0] quad;
  logic       rsvd_hit;
  logic       quad_bad;

  assign quad = ea[EA_W-1:QUAD_LO];

  generate
    if (RSVD_HI > 0) begin : g_rsvd
      assign rsvd_hit = |ea[RSVD_TOP:RSVD_BOT];
    end else begin : g_norsvd
      assign rsvd_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    quad_bad = 1'b0;
    sel_lpid = '0;
    sel_pid  = '0;
    if (hv_mode) begin
      unique case (quad)
        2'd0: sel_pid = cur_pid;
        2'd1: begin sel_lpid = cur_lpid; sel_pid = cur_pid; end
        2'd2: sel_lpid = cur_lpid;
        default: ;
      endcase
    end else begin
      unique case (quad)
        2'd0: begin sel_lpid = cur_lpid; sel_pid = cur_pid; end
        2'd3: sel_lpid = cur_lpid;
        default: quad_bad = 1'b1;
      endcase
    end
    seg_fault = rsvd_hit | quad_bad;
    if (seg_fault) begin
      sel_lpid = '0;
      sel_pid  = '0;
    end
  end
endmodule

// File: rtl/aq_cause_fold.sv
module aq_cause_fold #(
  parameter int CAUSE_W   = 32,
  parameter int STORE_BIT = 25
) (
  input  logic [CAUSE_W-1:0] cause_in,
  input  logic [1:0]         acc_type,
  output logic [CAUSE_W-1:0] cause_out
);
  import aq_pkg::*;
  localparam logic [CAUSE_W-1:0] STORE_MASK =
    {{(CAUSE_W-1){1'b0}}, 1'b1} << STORE_BIT;

  always_comb begin
    cause_out = cause_in;
    if (acc_e'(acc_type) == ACC_STORE) cause_out = cause_in | STORE_MASK;
  end
endmodule

// File: rtl/aq_fault_regs.sv
module aq_fault_regs #(
  parameter int EA_W    = 64,
  parameter int CAUSE_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strobe,
  input  logic [1:0]         fclass,
  input  logic [1:0]         acc_type,
  input  logic [EA_W-1:0]    ea,
  input  logic [EA_W-1:0]    graddr,
  input  logic [CAUSE_W-1:0] cause_raw,
  input  logic [CAUSE_W-1:0] cause_fold,
  output logic               flt_valid,
  output logic [2:0]         exc_idx,
  output logic [CAUSE_W-1:0] err_code,
  output logic [EA_W-1:0]    data_addr,
  output logic [CAUSE_W-1:0] data_stat,
  output logic [CAUSE_W-1:0] host_stat,
  output logic [EA_W-1:0]    host_addr,
  output logic [EA_W-1:0]    sec_addr
);
  import aq_pkg::*;

  logic load_en, is_fetch;
  logic en_exc, en_err, en_dar, en_dst, en_hst, en_hda, en_sec;
  exc_e exc_n;
  logic [CAUSE_W-1:0] err_n;

  assign load_en  = strobe && (fclass_e'(fclass) != FC_NONE);
  assign is_fetch = (acc_e'(acc_type) == ACC_FETCH);

  always_comb begin
    en_exc = load_en;
    en_err = load_en;
    en_dar = 1'b0;
    en_dst = 1'b0;
    en_hst = 1'b0;
    en_hda = 1'b0;
    en_sec = 1'b0;
    exc_n  = EX_NONE;
    err_n  = '0;
    unique case (fclass_e'(fclass))
      FC_SEG: begin
        exc_n  = is_fetch ? EX_ISEG : EX_DSEG;
        en_dar = load_en && !is_fetch;
      end
      FC_GUEST: begin
        if (is_fetch) begin
          exc_n = EX_ISTOR;
          err_n = cause_raw;
        end else begin
          exc_n  = EX_DSTOR;
          en_dar = load_en;
          en_dst = load_en;
        end
      end
      FC_HOST: begin
        en_sec = load_en;
        if (is_fetch) begin
          exc_n = EX_HISTOR;
          err_n = cause_raw;
        end else begin
          exc_n  = EX_HDSTOR;
          en_hst = load_en;
          en_hda = load_en;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_valid <= 1'b0;
      exc_idx   <= '0;
      err_code  <= '0;
      data_addr <= '0;
      data_stat <= '0;
      host_stat <= '0;
      host_addr <= '0;
      sec_addr  <= '0;
    end else begin
      flt_valid <= load_en;
      if (en_exc) exc_idx   <= exc_n;
      if (en_err) err_code  <= err_n;
      if (en_dar) data_addr <= ea;
      if (en_dst) data_stat <= cause_fold;
      if (en_hst) host_stat <= cause_fold;
      if (en_hda) host_addr <= ea;
      if (en_sec) sec_addr  <= graddr;
    end
  end
endmodule

// File: rtl/addr_qual_fault.sv
module addr_qual_fault #(
  parameter int EA_W      = 64,
  parameter int RSVD_HI   = 10,
  parameter int LPID_W    = 32,
  parameter int PID_W     = 32,
  parameter int CAUSE_W   = 32,
  parameter int STORE_BIT = 25
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [EA_W-1:0]    ea,
  input  logic               hv_mode,
  input  logic [1:0]         acc_type,
  input  logic [LPID_W-1:0]  cur_lpid,
  input  logic [PID_W-1:0]   cur_pid,
  output logic [LPID_W-1:0]  sel_lpid,
  output logic [PID_W-1:0]   sel_pid,
  output logic               seg_fault,
  input  logic               flt_strobe,
  input  logic [1:0]         flt_class,
  input  logic [CAUSE_W-1:0] flt_cause,
  input  logic [EA_W-1:0]    flt_graddr,
  output logic               flt_valid,
  output logic [2:0]         exc_idx,
  output logic [CAUSE_W-1:0] err_code,
  output logic [EA_W-1:0]    data_addr,
  output logic [CAUSE_W-1:0] data_stat,
  output logic [CAUSE_W-1:0] host_stat,
  output logic [EA_W-1:0]    host_addr,
  output logic [EA_W-1:0]    sec_addr
);
  logic [CAUSE_W-1:0] cause_fold;

  aq_quadrant_sel #(
    .EA_W(EA_W), .RSVD_HI(RSVD_HI), .LPID_W(LPID_W), .PID_W(PID_W)
  ) u_qsel (
    .ea(ea), .hv_mode(hv_mode), .cur_lpid(cur_lpid), .cur_pid(cur_pid),
    .sel_lpid(sel_lpid), .sel_pid(sel_pid), .seg_fault(seg_fault)
  );

  aq_cause_fold #(.CAUSE_W(CAUSE_W), .STORE_BIT(STORE_BIT)) u_fold (
    .cause_in(flt_cause), .acc_type(acc_type), .cause_out(cause_fold)
  );

  aq_fault_regs #(.EA_W(EA_W), .CAUSE_W(CAUSE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .strobe(flt_strobe), .fclass(flt_class),
    .acc_type(acc_type), .ea(ea), .graddr(flt_graddr),
    .cause_raw(flt_cause), .cause_fold(cause_fold),
    .flt_valid(flt_valid), .exc_idx(exc_idx), .err_code(err_code),
    .data_addr(data_addr), .data_stat(data_stat), .host_stat(host_stat),
    .host_addr(host_addr), .sec_addr(sec_addr)
  );
endmodule

// File: rtl/aq_check.sv
module aq_check #(
  parameter int EA_W      = 64,
  parameter int CAUSE_W   = 32,
  parameter int LPID_W    = 32,
  parameter int PID_W     = 32,
  parameter int STORE_BIT = 25
) (
  input logic               clk,
  input logic               rst_n,
  input logic [EA_W-1:0]    ea,
  input logic               hv_mode,
  input logic [1:0]         acc_type,
  input logic [LPID_W-1:0]  sel_lpid,
  input logic [PID_W-1:0]   sel_pid,
  input logic               seg_fault,
  input logic               flt_strobe,
  input logic [1:0]         flt_class,
  input logic               flt_valid,
  input logic [EA_W-1:0]    data_addr,
  input logic [CAUSE_W-1:0] data_stat,
  input logic [CAUSE_W-1:0] host_stat,
  input logic [EA_W-1:0]    sec_addr
);
  assert_zero_ids_R1: assert property (@(posedge clk) disable iff (!rst_n)
    seg_fault |-> (sel_lpid == '0 && sel_pid == '0));

  assert_guest_quad_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hv_mode && (ea[EA_W-1:EA_W-2] == 2'd1 || ea[EA_W-1:EA_W-2] == 2'd2))
      |-> seg_fault);

  assert_hv_q3_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hv_mode && ea[EA_W-1:EA_W-2] == 2'd3) |-> (sel_lpid == '0 && sel_pid == '0));

  assert_seg_fetch_keeps_dar_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_strobe && flt_class == 2'd0 && acc_type == 2'd0) |=> $stable(data_addr));

  assert_store_fold_guest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_strobe && flt_class == 2'd1 && acc_type == 2'd2) |=> data_stat[STORE_BIT]);

  assert_store_fold_host_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_strobe && flt_class == 2'd2 && acc_type == 2'd2) |=> host_stat[STORE_BIT]);

  assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_strobe && flt_class != 2'd3) |=> flt_valid);

  assert_no_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(flt_strobe && flt_class != 2'd3) |=> !flt_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_strobe |=> ($stable(data_addr) && $stable(sec_addr) &&
                     $stable(data_stat) && $stable(host_stat)));
endmodule

bind addr_qual_fault aq_check #(
  .EA_W(EA_W), .CAUSE_W(CAUSE_W), .LPID_W(LPID_W), .PID_W(PID_W),
  .STORE_BIT(STORE_BIT)
) u_aq_check (
  .clk(clk), .rst_n(rst_n), .ea(ea), .hv_mode(hv_mode), .acc_type(acc_type),
  .sel_lpid(sel_lpid), .sel_pid(sel_pid), .seg_fault(seg_fault),
  .flt_strobe(flt_strobe), .flt_class(flt_class), .flt_valid(flt_valid),
  .data_addr(data_addr), .data_stat(data_stat), .host_stat(host_stat),
  .sec_addr(sec_addr)
);

// File: tb/addr_qual_fault_test.sv
`timescale 1ns/1ps
module addr_qual_fault_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] ea;
  logic        hv_mode;
  logic [1:0]  acc_type;
  logic [31:0] cur_lpid, cur_pid, sel_lpid, sel_pid;
  logic        seg_fault, flt_strobe, flt_valid;
  logic [1:0]  flt_class;
  logic [31:0] flt_cause, err_code, data_stat, host_stat;
  logic [63:0] flt_graddr, data_addr, host_addr, sec_addr;
  logic [2:0]  exc_idx;

  int n_run = 0;
  int n_fail = 0;

  logic [2:0]  m_exc;
  logic [31:0] m_err, m_dst, m_hst;
  logic [63:0] m_dar, m_hda, m_sec;

  always #2.5 clk = ~clk;

  addr_qual_fault uut (
    .clk(clk), .rst_n(rst_n), .ea(ea), .hv_mode(hv_mode), .acc_type(acc_type),
    .cur_lpid(cur_lpid), .cur_pid(cur_pid), .sel_lpid(sel_lpid),
    .sel_pid(sel_pid), .seg_fault(seg_fault), .flt_strobe(flt_strobe),
    .flt_class(flt_class), .flt_cause(flt_cause), .flt_graddr(flt_graddr),
    .flt_valid(flt_valid), .exc_idx(exc_idx), .err_code(err_code),
    .data_addr(data_addr), .data_stat(data_stat), .host_stat(host_stat),
    .host_addr(host_addr), .sec_addr(sec_addr)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic exp_sel(input logic [63:0] a, input bit hv, output bit sf,
                         output logic [31:0] l, output logic [31:0] p);
    sf = 1'b0; l = '0; p = '0;
    if (|a[61:52]) sf = 1'b1;
    else if (hv) begin
      case (a[63:62])
        2'd0: p = cur_pid;
        2'd1: begin l = cur_lpid; p = cur_pid; end
        2'd2: l = cur_lpid;
        default: ;
      endcase
    end else begin
      case (a[63:62])
        2'd0: begin l = cur_lpid; p = cur_pid; end
        2'd3: l = cur_lpid;
        default: sf = 1'b1;
      endcase
    end
  endtask

  function automatic logic [31:0] fold(input logic [31:0] c, input logic [1:0] acc);
    return (acc == 2'd2) ? (c | 32'h0200_0000) : c;
  endfunction

  task automatic model_update(input logic [1:0] cls);
    bit f;
    f = (acc_type == 2'd0);
    case (cls)
      2'd0: begin
        m_exc = f ? 3'd1 : 3'd2; m_err = '0;
        if (!f) m_dar = ea;
      end
      2'd1: begin
        if (f) begin m_exc = 3'd3; m_err = flt_cause; end
        else begin
          m_exc = 3'd4; m_err = '0; m_dar = ea;
          m_dst = fold(flt_cause, acc_type);
        end
      end
      2'd2: begin
        m_sec = flt_graddr;
        if (f) begin m_exc = 3'd5; m_err = flt_cause; end
        else begin
          m_exc = 3'd6; m_err = '0; m_hda = ea;
          m_hst = fold(flt_cause, acc_type);
        end
      end
      default: ;
    endcase
  endtask

  task automatic op(input logic [63:0] a, input bit hv, input logic [1:0] acc,
                    input bit stb, input logic [1:0] cls, input logic [31:0] cause,
                    input logic [63:0] gra);
    bit sf; logic [31:0] el, ep; string tg;
    @(negedge clk);
    ea = a; hv_mode = hv; acc_type = acc; flt_strobe = stb;
    flt_class = cls; flt_cause = cause; flt_graddr = gra;
    #1;
    exp_sel(a, hv, sf, el, ep);
    tg = (|a[61:52]) ? "R1" : (hv ? "R2" : "R3");
    check(seg_fault == sf && sel_lpid == el && sel_pid == ep, tg,
          {sel_lpid, sel_pid}, {el, ep});
    if (stb) model_update(cls);
    @(negedge clk);
    flt_strobe = 1'b0;
    tg = !stb || cls == 2'd3 ? "R8" : (cls == 2'd0 ? "R4" :
         (acc == 2'd2 ? "R6" : (cls == 2'd1 ? "R5" : "R7")));
    check(flt_valid == (stb && cls != 2'd3), "R8", {63'd0, flt_valid},
          {63'd0, stb && cls != 2'd3});
    check(exc_idx == m_exc && err_code == m_err, tg, {29'd0, exc_idx, err_code},
          {29'd0, m_exc, m_err});
    check(data_addr == m_dar && data_stat == m_dst, tg, data_addr ^ {32'd0, data_stat},
          m_dar ^ {32'd0, m_dst});
    check(host_addr == m_hda && host_stat == m_hst && sec_addr == m_sec, tg,
          host_addr ^ sec_addr ^ {32'd0, host_stat}, m_hda ^ m_sec ^ {32'd0, m_hst});
  endtask

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; ea = '0; hv_mode = 1'b0; acc_type = '0; cur_lpid = 32'h0000_0A11;
    cur_pid = 32'h0000_0B22; flt_strobe = 1'b0; flt_class = 2'd3;
    flt_cause = '0; flt_graddr = '0;
    m_exc = '0; m_err = '0; m_dst = '0; m_hst = '0; m_dar = '0; m_hda = '0; m_sec = '0;
    repeat (3) @(negedge clk);
    // R9: everything zero in reset
    check(flt_valid == 0 && exc_idx == 0 && err_code == 0 && data_addr == 0 &&
          data_stat == 0 && host_stat == 0 && host_addr == 0 && sec_addr == 0,
          "R9", {data_addr ^ sec_addr ^ host_addr}, 64'd0);
    rst_n = 1'b1;
    // R2 / R3 quadrant sweep
    for (int q = 0; q < 4; q++) begin
      op({q[1:0], 62'h123}, 1'b1, 2'd1, 1'b0, 2'd0, 32'd0, 64'd0);
      op({q[1:0], 62'h456}, 1'b0, 2'd1, 1'b0, 2'd0, 32'd0, 64'd0);
    end
    // R1: reserved bit in a legal quadrant
    op({2'd0, 10'b0000000001, 52'h5}, 1'b1, 2'd1, 1'b0, 2'd0, 32'd0, 64'd0);
    op({2'd3, 10'b1000000000, 52'h5}, 1'b0, 2'd1, 1'b0, 2'd0, 32'd0, 64'd0);
    // R4: data segment fault loads address, fetch segment fault keeps it
    op(64'h4000_0000_0000_1000, 1'b0, 2'd1, 1'b1, 2'd0, 32'hFFFF, 64'd0);
    op(64'h4000_0000_0000_2000, 1'b0, 2'd0, 1'b1, 2'd0, 32'hFFFF, 64'd0);
    // R5 guest fetch and load, R6 guest store
    op(64'h10, 1'b0, 2'd0, 1'b1, 2'd1, 32'h4000_0000, 64'd0);
    op(64'h20, 1'b0, 2'd1, 1'b1, 2'd1, 32'h4000_0000, 64'd0);
    op(64'h30, 1'b0, 2'd2, 1'b1, 2'd1, 32'h0800_0000, 64'd0);
    // R7 host fetch and load, R6 host store
    op(64'h40, 1'b1, 2'd0, 1'b1, 2'd2, 32'h0000_0100, 64'hAAAA_0000);
    op(64'h50, 1'b1, 2'd1, 1'b1, 2'd2, 32'h0000_0200, 64'hBBBB_0000);
    op(64'h60, 1'b1, 2'd2, 1'b1, 2'd2, 32'h0000_0300, 64'hCCCC_0000);
    // R8: class 3 ignored, idle holds
    op(64'h70, 1'b1, 2'd2, 1'b1, 2'd3, 32'hDEAD_BEEF, 64'h1);
    op(64'h80, 1'b0, 2'd1, 1'b0, 2'd1, 32'hDEAD_BEEF, 64'h2);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a;
      a = {$urandom, $urandom};
      if ($urandom % 4 != 0) a[61:52] = '0;
      cur_lpid = $urandom; cur_pid = $urandom;
      op(a, 1'($urandom), 2'($urandom % 3), 1'($urandom), 2'($urandom),
         $urandom, {$urandom, $urandom});
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule